// File: doc/BRIEF.md
# Reversible Carry-Select BCD Digit Adder

This block adds two decimal digits, each held in four bits with values 0 to 9, together with an incoming decimal carry. It returns one corrected decimal digit and a decimal carry. The arithmetic is built only from instances of reversible gate primitives. Each primitive maps its inputs one-to-one onto its outputs. A three-line copy gate stands in for wire fan-out. A five-line fault-tolerant full adder forms sums. A controlled-swap gate acts as a two-way selector. A three-line universal gate provides the AND, OR and XOR terms for decimal correction.

Each bit position computes two results ahead of time, one for an incoming carry of 0 and one for 1. The real carry then drives the control line of two swap gates that pick the sum bit and the carry out. The binary result goes to a correction stage. When the binary total is above 9, that stage adds six and raises the decimal carry. Every gate output that is not a result leaves the block on a 39-bit garbage bus. The network holds 24 gate instances: five per bit position and four for correction.

Operands arrive on a valid/ready input channel. Each accepted operand pair becomes one result on a valid/ready output channel that has one register stage. A result stays on the output, unchanged, until the consumer takes it with out_ready. While a result is held and out_ready is low, in_ready is low and no new operands are taken. With out_ready held high, one pair is accepted every cycle.

Top module: `rcs_bcd_digit_adder`

## Requirements
- R1: For every in_a and in_b in 0..9 and both values of in_cin, the accepted result has out_digit = (in_a+in_b+in_cin) mod 10 and out_carry = 1 exactly when that total is 10 or more. This covers totals of 10..15 and the binary-overflow totals 16..19.
- R2: Whenever out_valid is high, out_digit is 9 or less.
- R3: The copy gate gives P=A, Q=A xor B, R=A xor C. Its 8 input codes map to 8 distinct output codes.
- R4: The controlled-swap gate passes its control line through. With control 0 its two data lines pass straight through; with control 1 they trade places. Its 8 input codes map to 8 distinct outputs.
- R5: The universal gate gives P=A, Q=(A and B) xor C, R=((not A) and (not C)) xor (not B). It is a bijection on 8 codes.
- R6: The full-adder primitive (inputs x, y, ci, k0, k1) gives pass_x=x, mix_xy=x xor y xor k0, sum=x xor y xor ci, carry=majority(x,y,ci) xor k1, pass_ci=ci. It is a bijection on 32 codes.
- R7: out_garbage is 39 bits wide. Bit position i (0..3) owns slots 9i..9i+8. Slot 9i holds in_b[i]. Slot 9i+2 holds 0. Slot 9i+3 holds in_a[i]. Slot 9i+5 holds 1. Slot 9i+7 holds the binary carry into bit i: in_cin for bit 0, and otherwise bit i of (in_a mod 2^i)+(in_b mod 2^i)+in_cin. These slots are enough to recover the inputs.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_digit, out_carry and out_garbage stay unchanged at the next clock.
- R9: During and right after reset, out_valid is low and in_ready is high.
- R10: A transfer (in_valid and in_ready) makes out_valid high in the next cycle. With out_ready held high, in_ready never drops, so one pair is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 4 | First decimal digit, 0..9 |
| in_b | input | 4 | Second decimal digit, 0..9 |
| in_cin | input | 1 | Incoming decimal carry |
| out_valid | output | 1 | Result held on the output |
| out_ready | input | 1 | Consumer takes the result |
| out_digit | output | 4 | Corrected decimal digit |
| out_carry | output | 1 | Decimal carry out |
| out_garbage | output | 39 | Unused reversible gate outputs, slot layout in R7 |

## Verification
All 200 valid digit and carry combinations are applied. Totals of 0..9 show that the correction stays off. Totals of 10..15 exercise the add-six path. Totals of 16..19 exercise the binary carry path, where the OR in the flag logic is formed as an exclusive OR. The same sweep is run once with out_ready held high, which tests one-per-cycle throughput, and once with a periodic stall, which shows that held results do not move. Each gate primitive is also driven through every input code: its equations are checked, and distinct outputs confirm that it is a bijection.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DIGIT_W    = 4;
  localparam int SLICE_GARB = 9;
  localparam int FIX_GARB   = 3;
  localparam int GARB_W     = DIGIT_W * SLICE_GARB + FIX_GARB;
  localparam int SLICE_GATES = 5;
  localparam int FIX_GATES   = 4;
  localparam int GATE_TOTAL  = DIGIT_W * SLICE_GATES + FIX_GATES;

  // garbage slot positions inside one bit slice
  localparam int SL_B_SPARE  = 0;
  localparam int SL_XOR0     = 1;
  localparam int SL_K0       = 2;
  localparam int SL_A_ECHO   = 3;
  localparam int SL_XOR1     = 4;
  localparam int SL_K1       = 5;
  localparam int SL_SUM_ALT  = 6;
  localparam int SL_CIN_ECHO = 7;
  localparam int SL_CY_ALT   = 8;

  typedef struct packed {
    logic [DIGIT_W-1:0] digit;
    logic               carry;
    logic [GARB_W-1:0]  garb;
  } rcs_result_t;
endpackage

// File: rtl/rv_copy3.sv
module rv_copy3 (
  input  logic in0,
  input  logic in1,
  input  logic in2,
  output logic out0,
  output logic out1,
  output logic out2
);
  assign out0 = in0;
  assign out1 = in0 ^ in1;
  assign out2 = in0 ^ in2;
endmodule

// File: rtl/rv_swap3.sv
module rv_swap3 (
  input  logic ctl,
  input  logic x,
  input  logic y,
  output logic ctl_o,
  output logic out_x,
  output logic out_y
);
  assign ctl_o = ctl;
  assign out_x = ctl ? y : x;
  assign out_y = ctl ? x : y;
endmodule

// File: rtl/rv_univ3.sv
module rv_univ3 (
  input  logic in0,
  input  logic in1,
  input  logic in2,
  output logic out0,
  output logic out1,
  output logic out2
);
  assign out0 = in0;
  assign out1 = (in0 & in1) ^ in2;
  assign out2 = (~in0 & ~in2) ^ ~in1;
endmodule

// File: rtl/rv_ftfa.sv
module rv_ftfa (
  input  logic x,
  input  logic y,
  input  logic ci,
  input  logic k0,
  input  logic k1,
  output logic pass_x,
  output logic mix_xy,
  output logic sum,
  output logic carry,
  output logic pass_ci
);
  assign pass_x  = x;
  assign mix_xy  = x ^ y ^ k0;
  assign sum     = x ^ y ^ ci;
  assign carry   = ((x & y) | (x & ci) | (y & ci)) ^ k1;
  assign pass_ci = ci;
endmodule

// File: rtl/rcs_bit_slice.sv
module rcs_bit_slice
  import rcs_pkg::*;
(
  input  logic                  a,
  input  logic                  b,
  input  logic                  cin,
  output logic                  sum,
  output logic                  cout,
  output logic [SLICE_GARB-1:0] garb
);
  logic b_p, b_q, a_fwd, cin_fwd;
  logic s0, c0, s1, c1;

  // three copies of b: two feed the adders, one is spare
  rv_copy3 u_dup (
    .in0(b), .in1(1'b0), .in2(1'b0),
    .out0(b_p), .out1(b_q), .out2(garb[SL_B_SPARE])
  );

  // speculative adder for carry-in 0; its pass-through of a feeds the other adder
  rv_ftfa u_fa_lo (
    .x(a), .y(b_p), .ci(1'b0), .k0(1'b0), .k1(1'b0),
    .pass_x(a_fwd), .mix_xy(garb[SL_XOR0]), .sum(s0), .carry(c0),
    .pass_ci(garb[SL_K0])
  );

  // speculative adder for carry-in 1
  rv_ftfa u_fa_hi (
    .x(a_fwd), .y(b_q), .ci(1'b1), .k0(1'b0), .k1(1'b0),
    .pass_x(garb[SL_A_ECHO]), .mix_xy(garb[SL_XOR1]), .sum(s1), .carry(c1),
    .pass_ci(garb[SL_K1])
  );

  // real carry selects the sum, then travels on to select the carry
  rv_swap3 u_sel_sum (
    .ctl(cin), .x(s0), .y(s1),
    .ctl_o(cin_fwd), .out_x(sum), .out_y(garb[SL_SUM_ALT])
  );

  rv_swap3 u_sel_cy (
    .ctl(cin_fwd), .x(c0), .y(c1),
    .ctl_o(garb[SL_CIN_ECHO]), .out_x(cout), .out_y(garb[SL_CY_ALT])
  );
endmodule

// File: rtl/rcs_decimal_fix.sv
module rcs_decimal_fix
  import rcs_pkg::*;
(
  input  logic [DIGIT_W-1:0]  bin,
  input  logic                k,
  output logic [DIGIT_W-1:0]  digit,
  output logic                dcarry,
  output logic [FIX_GARB-1:0] garb
);
  logic z2_f, z1_f, any21, z3_f, flag, flag_f, c2;

  // OR of bits 2 and 1, both bits passed on
  rv_univ3 u_or21 (
    .in0(bin[2]), .in1(1'b0), .in2(bin[1]),
    .out0(z2_f), .out1(z1_f), .out2(any21)
  );

  // flag = k | (z3 & (z2|z1)); the two terms never meet for valid digits, so xor serves
  rv_univ3 u_flag (
    .in0(bin[3]), .in1(any21), .in2(k),
    .out0(z3_f), .out1(flag), .out2(garb[0])
  );

  // half adder at bit 1: adds flag, passes flag on
  rv_univ3 u_half (
    .in0(flag), .in1(z1_f), .in2(1'b0),
    .out0(flag_f), .out1(c2), .out2(digit[1])
  );

  // bit 2 sum; carry folded with bit 3 through the k1 line
  rv_ftfa u_upper (
    .x(flag_f), .y(z2_f), .ci(c2), .k0(1'b0), .k1(z3_f),
    .pass_x(dcarry), .mix_xy(garb[1]), .sum(digit[2]), .carry(digit[3]),
    .pass_ci(garb[2])
  );

  assign digit[0] = bin[0];
endmodule

// File: rtl/rcs_bcd_digit_adder.sv
module rcs_bcd_digit_adder
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIGIT_W-1:0] in_a,
  input  logic [DIGIT_W-1:0] in_b,
  input  logic               in_cin,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DIGIT_W-1:0] out_digit,
  output logic               out_carry,
  output logic [GARB_W-1:0]  out_garbage
);
  logic [DIGIT_W:0]   cy;
  logic [DIGIT_W-1:0] bin;
  logic [DIGIT_W-1:0] dig_c;
  logic               dc_c;
  logic [GARB_W-1:0]  garb_c;
  logic               valid_q;
  logic               take;
  rcs_result_t        res_q;

  assign cy[0] = in_cin;

  generate
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_slice
      rcs_bit_slice u_slice (
        .a(in_a[i]), .b(in_b[i]), .cin(cy[i]),
        .sum(bin[i]), .cout(cy[i+1]),
        .garb(garb_c[i*SLICE_GARB +: SLICE_GARB])
      );
    end
  endgenerate

  rcs_decimal_fix u_fix (
    .bin(bin), .k(cy[DIGIT_W]),
    .digit(dig_c), .dcarry(dc_c),
    .garb(garb_c[GARB_W-1 -: FIX_GARB])
  );

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      if (take) begin
        valid_q     <= 1'b1;
        res_q.digit <= dig_c;
        res_q.carry <= dc_c;
        res_q.garb  <= garb_c;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_digit   = res_q.digit;
  assign out_carry   = res_q.carry;
  assign out_garbage = res_q.garb;

  // R1
  decimal_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a <= 4'd9 && in_b <= 4'd9) |=>
      (({1'b0, out_digit} + (out_carry ? 5'd10 : 5'd0)) ==
       ({1'b0, $past(in_a)} + {1'b0, $past(in_b)} + {4'b0, $past(in_cin)})));

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_digit <= 4'd9));

  // R7
  cin_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_garbage[SL_CIN_ECHO] == $past(in_cin)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_digit) && $stable(out_carry) && $stable(out_garbage)));

  // R10
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/tb_rcs_bcd_digit_adder.sv
module tb_rcs_bcd_digit_adder;
  import rcs_pkg::*;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [DIGIT_W-1:0] in_a = '0;
  logic [DIGIT_W-1:0] in_b = '0;
  logic               in_cin = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [DIGIT_W-1:0] out_digit;
  logic               out_carry;
  logic [GARB_W-1:0]  out_garbage;

  rcs_bcd_digit_adder dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_digit(out_digit), .out_carry(out_carry), .out_garbage(out_garbage)
  );

  // standalone primitives for exhaustive checks
  logic [2:0] cg_i = '0, sw_i = '0, ng_i = '0;
  logic [4:0] fa_i = '0;
  logic cg_p, cg_q, cg_r, sw_c, sw_x, sw_y, ng_p, ng_q, ng_r;
  logic fa_px, fa_mx, fa_s, fa_c, fa_pc;

  rv_copy3 u_cg (.in0(cg_i[2]), .in1(cg_i[1]), .in2(cg_i[0]),
                 .out0(cg_p), .out1(cg_q), .out2(cg_r));
  rv_swap3 u_sw (.ctl(sw_i[2]), .x(sw_i[1]), .y(sw_i[0]),
                 .ctl_o(sw_c), .out_x(sw_x), .out_y(sw_y));
  rv_univ3 u_ng (.in0(ng_i[2]), .in1(ng_i[1]), .in2(ng_i[0]),
                 .out0(ng_p), .out1(ng_q), .out2(ng_r));
  rv_ftfa  u_fa (.x(fa_i[4]), .y(fa_i[3]), .ci(fa_i[2]), .k0(fa_i[1]), .k1(fa_i[0]),
                 .pass_x(fa_px), .mix_xy(fa_mx), .sum(fa_s), .carry(fa_c), .pass_ci(fa_pc));

  int n_checks = 0;
  int n_fail   = 0;
  int received = 0;
  int waits    = 0;
  int stalls   = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  typedef struct { int a; int b; int c; } item_t;
  item_t sb_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // driver: offers one pair, pushes expected item on acceptance
  task automatic send(input int a, input int b, input int c);
    item_t it;
    @(negedge clk);
    in_a = a[3:0]; in_b = b[3:0]; in_cin = c[0]; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    it.a = a; it.b = b; it.c = c;
    sb_q.push_back(it);
  endtask

  // consumer ready pattern
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_mode ? ((cyc % 3) != 2) : 1'b1;
  end

  // monitor / scoreboard
  bit                prev_stall = 1'b0;
  logic [DIGIT_W-1:0] held_d;
  logic               held_c;
  logic [GARB_W-1:0]  held_g;

  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        // R8: held result unchanged after a stalled edge
        check(out_valid && out_digit == held_d && out_carry == held_c && out_garbage == held_g,
              "R8", "held result", longint'(out_digit), longint'(held_d));
        stalls++;
      end
      prev_stall = out_valid && !out_ready;
      held_d = out_digit; held_c = out_carry; held_g = out_garbage;
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", 1, 0);
        end else begin
          item_t it;
          int total, exp_d, exp_c, bad;
          it = sb_q.pop_front();
          received++;
          total = it.a + it.b + it.c;
          exp_d = total % 10;
          exp_c = (total >= 10) ? 1 : 0;
          check(out_digit == exp_d[3:0], "R1", "digit", longint'(out_digit), exp_d);
          check(out_carry == exp_c[0], "R1", "decimal carry", longint'(out_carry), exp_c);
          check(out_digit <= 4'd9, "R2", "digit range", longint'(out_digit), 9);
          bad = 0;
          for (int i = 0; i < DIGIT_W; i++) begin
            int m, cin_i;
            m = (1 << i) - 1;
            cin_i = (((it.a & m) + (it.b & m) + it.c) >> i) & 1;
            if (out_garbage[i*SLICE_GARB + 0] != ((it.b >> i) & 1)) bad++;
            if (out_garbage[i*SLICE_GARB + 2] != 1'b0) bad++;
            if (out_garbage[i*SLICE_GARB + 3] != ((it.a >> i) & 1)) bad++;
            if (out_garbage[i*SLICE_GARB + 5] != 1'b1) bad++;
            if (out_garbage[i*SLICE_GARB + 7] != cin_i[0]) bad++;
          end
          check(bad == 0, "R7", "garbage slot mismatches", bad, 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", received, 400);
      summary();
      $finish;
    end
  end

  initial begin
    // R3: copy gate equations and bijection
    begin
      logic [7:0] seen = '0;
      int bad = 0;
      for (int v = 0; v < 8; v++) begin
        cg_i = v[2:0];
        #1;
        if (cg_p != cg_i[2] || cg_q != (cg_i[2] ^ cg_i[1]) || cg_r != (cg_i[2] ^ cg_i[0])) bad++;
        seen[{cg_p, cg_q, cg_r}] = 1'b1;
      end
      check(bad == 0, "R3", "copy gate equations", bad, 0);
      check($countones(seen) == 8, "R3", "copy gate distinct outputs", $countones(seen), 8);
    end
    // R4: controlled swap
    begin
      logic [7:0] seen = '0;
      int bad = 0;
      for (int v = 0; v < 8; v++) begin
        sw_i = v[2:0];
        #1;
        if (sw_c != sw_i[2]) bad++;
        if (sw_i[2] == 1'b0 && (sw_x != sw_i[1] || sw_y != sw_i[0])) bad++;
        if (sw_i[2] == 1'b1 && (sw_x != sw_i[0] || sw_y != sw_i[1])) bad++;
        seen[{sw_c, sw_x, sw_y}] = 1'b1;
      end
      check(bad == 0, "R4", "swap gate behaviour", bad, 0);
      check($countones(seen) == 8, "R4", "swap gate distinct outputs", $countones(seen), 8);
    end
    // R5: universal gate
    begin
      logic [7:0] seen = '0;
      int bad = 0;
      for (int v = 0; v < 8; v++) begin
        ng_i = v[2:0];
        #1;
        if (ng_p != ng_i[2]) bad++;
        if (ng_q != ((ng_i[2] & ng_i[1]) ^ ng_i[0])) bad++;
        if (ng_r != ((~ng_i[2] & ~ng_i[0]) ^ ~ng_i[1])) bad++;
        seen[{ng_p, ng_q, ng_r}] = 1'b1;
      end
      check(bad == 0, "R5", "universal gate equations", bad, 0);
      check($countones(seen) == 8, "R5", "universal gate distinct outputs", $countones(seen), 8);
    end
    // R6: full-adder primitive
    begin
      logic [31:0] seen = '0;
      int bad = 0;
      for (int v = 0; v < 32; v++) begin
        logic x, y, c, k0, k1, mj;
        fa_i = v[4:0];
        #1;
        {x, y, c, k0, k1} = fa_i;
        mj = (x & y) | (x & c) | (y & c);
        if (fa_px != x || fa_mx != (x ^ y ^ k0) || fa_s != (x ^ y ^ c) ||
            fa_c != (mj ^ k1) || fa_pc != c) bad++;
        seen[{fa_px, fa_mx, fa_s, fa_c, fa_pc}] = 1'b1;
      end
      check(bad == 0, "R6", "full adder equations", bad, 0);
      check($countones(seen) == 32, "R6", "full adder distinct outputs", $countones(seen), 32);
    end

    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);

    // R1 R10: full sweep with consumer always ready
    waits = 0;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 10; a++)
        for (int b = 0; b < 10; b++)
          send(a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    check(waits == 0, "R10", "input waits with ready held high", waits, 0);

    // R8: same sweep under periodic stall
    repeat (3) @(negedge clk);
    stall_mode = 1'b1;
    for (int c = 1; c >= 0; c--)
      for (int a = 9; a >= 0; a--)
        for (int b = 0; b < 10; b++)
          send(a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 50 && sb_q.size() != 0; i++) @(negedge clk);
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    check(stalls > 0, "R8", "stalls observed", stalls, 1);
    check(received == 400, "R1", "results received", received, 400);
    check(sb_q.size() == 0, "R10", "results left over", sb_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule